// File: doc/BRIEF.md
# Packed Lane Compare and Rounding Average Unit

This block is a 128-bit packed integer execution stage. Each transaction carries two 128-bit operands and a three-byte opcode: an operand-size prefix byte, an escape byte and an operation byte. From these the block selects one of five lane operations. Lane-wise equality is available at three lane widths (8, 16 and 32 bits). The byte lanes also have a signed strictly-greater compare. The fifth operation is an unsigned rounding average on 16-bit lanes. Compare results are lane masks: every bit of a lane is 1 when the condition holds and 0 when it does not. The result is the value that would be written back over the first operand.

Transactions are accepted whenever `in_valid` is high, because `in_ready` is always high. The result is registered and appears one cycle after acceptance. A small two-state controller tracks the result slot:
- `ST_IDLE` holds no fresh result. It moves to `ST_RESULT` on an accepted input (transition T_ISSUE) and stays in `ST_IDLE` otherwise.
- `ST_RESULT` presents a fresh result with `out_valid` high. It stays in `ST_RESULT` when another input is accepted in the same cycle (T_CHAIN) and returns to `ST_IDLE` when none is (T_DRAIN).

An opcode that is not recognised raises `illegal`, and the result is then a copy of the first operand. The block has no flag outputs, and no operation alters any condition or control state.

Top module: `simd_cmpavg_unit`

## Requirements
- R1: After reset, `out_valid`, `illegal` and `result` are all 0, and `in_ready` is 1.
- R2: `out_valid` is high in the cycle after an accepted input (`in_valid` high at a rising edge) and low in the cycle after any edge without one; `in_ready` is always 1.
- R3: With prefix 66h, escape 0Fh and operation byte 74h, each 8-bit result lane is FFh when the two operand bytes are equal and 00h otherwise.
- R4: With operation byte 75h (same prefix and escape), each 16-bit result lane is FFFFh when the two operand lanes are equal and 0000h otherwise.
- R5: With operation byte 76h, each 32-bit result lane is all ones when the two operand lanes are equal and all zeros otherwise.
- R6: With operation byte 64h, the byte lanes are two's-complement signed values; a result lane is FFh only when the first operand lane is strictly greater than the second, and 00h when it is less or equal.
- R7: With operation byte E3h, each unsigned 16-bit lane i (bits 16i+15:16i, i = 0..7) of the result is (a + b + 1) >> 1, computed without losing the carry out of bit 15.
- R8: No carry and no compare outcome crosses a lane boundary: each result lane depends only on the same lane of the two operands.
- R9: An operation byte other than 74h, 75h, 76h, 64h or E3h sets `illegal` to 1 and makes `result` equal to the first operand; a recognised opcode sets `illegal` to 0.
- R10: A prefix byte other than 66h or an escape byte other than 0Fh makes the opcode unrecognised, with the same outcome as R9.
- R11: `result` and `illegal` keep their values across every edge at which no input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are presented |
| in_ready | output | 1 | Unit can accept an input (always 1) |
| op_prefix | input | 8 | Operand-size prefix byte, must be 66h |
| op_escape | input | 8 | Escape byte, must be 0Fh |
| op_code | input | 8 | Operation byte |
| src_a | input | 128 | First operand (destination) |
| src_b | input | 128 | Second operand |
| out_valid | output | 1 | Registered result is fresh this cycle |
| result | output | 128 | Registered lane result |
| illegal | output | 1 | Opcode of the last accepted input was unrecognised |

## Verification
The bench builds the unit with its default 128-bit width. At that width there are sixteen byte lanes, eight 16-bit lanes and four 32-bit lanes, so operand patterns can place an equal lane beside an unequal one at every lane width. The same width lets the bench hit the top lane (bits 127:112) and the bottom lane, the signed byte boundary between 7Fh and 80h, and 16-bit averages whose carry out of bit 15 must be kept. Back-to-back and idle cycles cover all three controller transitions.

// File: rtl/simd_cav_pkg.sv
package simd_cav_pkg;

    localparam logic [7:0] PFX_OPSIZE = 8'h66;
    localparam logic [7:0] ESC_TWO    = 8'h0F;
    localparam logic [7:0] OPC_EQ8    = 8'h74;
    localparam logic [7:0] OPC_EQ16   = 8'h75;
    localparam logic [7:0] OPC_EQ32   = 8'h76;
    localparam logic [7:0] OPC_GT8    = 8'h64;
    localparam logic [7:0] OPC_AVG16  = 8'hE3;

    typedef enum logic [2:0] {
        OPK_EQ8   = 3'd0,
        OPK_EQ16  = 3'd1,
        OPK_EQ32  = 3'd2,
        OPK_GT8   = 3'd3,
        OPK_AVG16 = 3'd4,
        OPK_BAD   = 3'd5
    } op_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fsm_state_e;

endpackage

// File: rtl/simd_cav_decode.sv
module simd_cav_decode
    import simd_cav_pkg::*;
(
    input  logic [7:0] op_prefix,
    input  logic [7:0] op_escape,
    input  logic [7:0] op_code,
    output op_kind_e   kind
);

    logic frame_ok;

    assign frame_ok = (op_prefix == PFX_OPSIZE) && (op_escape == ESC_TWO);

    always_comb begin
        kind = OPK_BAD;
        if (frame_ok) begin
            unique case (op_code)
                OPC_EQ8:   kind = OPK_EQ8;
                OPC_EQ16:  kind = OPK_EQ16;
                OPC_EQ32:  kind = OPK_EQ32;
                OPC_GT8:   kind = OPK_GT8;
                OPC_AVG16: kind = OPK_AVG16;
                default:   kind = OPK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/simd_cav_lane_cmp.sv
module simd_cav_lane_cmp #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8,
    parameter bit CMP_GT = 1'b0
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] mask
);

    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la;
        logic [LANE_W-1:0] lb;
        logic              hit;

        assign la = a[i*LANE_W +: LANE_W];
        assign lb = b[i*LANE_W +: LANE_W];

        if (CMP_GT) begin : g_gt
            assign hit = $signed(la) > $signed(lb);
        end else begin : g_eq
            assign hit = (la == lb);
        end

        assign mask[i*LANE_W +: LANE_W] = {LANE_W{hit}};
    end

endmodule

// File: rtl/simd_cav_avg.sv
module simd_cav_avg #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] avg
);

    localparam int N_LANES = DATA_W / LANE_W;
    localparam int SUM_W   = LANE_W + 1;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [SUM_W-1:0] wa;
        logic [SUM_W-1:0] wb;

        assign wa = {1'b0, a[i*LANE_W +: LANE_W]};
        assign wb = {1'b0, b[i*LANE_W +: LANE_W]};
        assign avg[i*LANE_W +: LANE_W] = LANE_W'((wa + wb + SUM_W'(1)) >> 1);
    end

endmodule

// File: rtl/simd_cmpavg_unit.sv
module simd_cmpavg_unit
    import simd_cav_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        op_prefix,
    input  logic [7:0]        op_escape,
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);

    op_kind_e          kind;
    fsm_state_e        state_q;
    fsm_state_e        state_d;
    logic              accept;
    logic [DATA_W-1:0] eq8_m;
    logic [DATA_W-1:0] eq16_m;
    logic [DATA_W-1:0] eq32_m;
    logic [DATA_W-1:0] gt8_m;
    logic [DATA_W-1:0] avg_v;
    logic [DATA_W-1:0] sel_v;
    logic [DATA_W-1:0] result_q;
    logic              illegal_q;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;

    simd_cav_decode u_dec (
        .op_prefix (op_prefix),
        .op_escape (op_escape),
        .op_code   (op_code),
        .kind      (kind)
    );

    simd_cav_lane_cmp #(.DATA_W(DATA_W), .LANE_W(8), .CMP_GT(1'b0)) u_eq8 (
        .a(src_a), .b(src_b), .mask(eq8_m)
    );

    simd_cav_lane_cmp #(.DATA_W(DATA_W), .LANE_W(16), .CMP_GT(1'b0)) u_eq16 (
        .a(src_a), .b(src_b), .mask(eq16_m)
    );

    simd_cav_lane_cmp #(.DATA_W(DATA_W), .LANE_W(32), .CMP_GT(1'b0)) u_eq32 (
        .a(src_a), .b(src_b), .mask(eq32_m)
    );

    simd_cav_lane_cmp #(.DATA_W(DATA_W), .LANE_W(8), .CMP_GT(1'b1)) u_gt8 (
        .a(src_a), .b(src_b), .mask(gt8_m)
    );

    simd_cav_avg #(.DATA_W(DATA_W), .LANE_W(16)) u_avg (
        .a(src_a), .b(src_b), .avg(avg_v)
    );

    // Result select: an unrecognised opcode passes the destination through.
    always_comb begin
        unique case (kind)
            OPK_EQ8:   sel_v = eq8_m;
            OPK_EQ16:  sel_v = eq16_m;
            OPK_EQ32:  sel_v = eq32_m;
            OPK_GT8:   sel_v = gt8_m;
            OPK_AVG16: sel_v = avg_v;
            default:   sel_v = src_a;
        endcase
    end

    // Next-state logic of the result slot controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = accept ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result register, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            illegal_q <= 1'b0;
        end else if (accept) begin
            result_q  <= sel_v;
            illegal_q <= (kind == OPK_BAD);
        end
    end

    // Outputs.
    always_comb begin
        out_valid = (state_q == ST_RESULT);
        result    = result_q;
        illegal   = illegal_q;
    end

endmodule

// File: rtl/simd_cav_chk.sv
module simd_cav_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        op_prefix,
    input logic [7:0]        op_escape,
    input logic [7:0]        op_code,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal
);

    logic take;
    logic frame_ok;
    logic code_known;

    assign take       = in_valid && in_ready;
    assign frame_ok   = (op_prefix == 8'h66) && (op_escape == 8'h0F);
    assign code_known = (op_code == 8'h74) || (op_code == 8'h75) || (op_code == 8'h76)
                     || (op_code == 8'h64) || (op_code == 8'hE3);

    // R2
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

    // R2
    valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);

    // R2
    no_valid_without_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !out_valid);

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(result) && $stable(illegal)));

    // R9
    bad_code_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_ok && !code_known) |=> (illegal && result == $past(src_a)));

    // R10
    bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !frame_ok) |=> (illegal && result == $past(src_a)));

    // R9
    good_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_ok && code_known) |=> !illegal);

    // R3
    eq8_same_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_ok && op_code == 8'h74 && src_a == src_b) |=> (result == '1));

    // R6
    gt8_same_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_ok && op_code == 8'h64 && src_a == src_b) |=> (result == '0));

endmodule

bind simd_cmpavg_unit simd_cav_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_prefix (op_prefix),
    .op_escape (op_escape),
    .op_code   (op_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/tb_simd_cmpavg_unit.sv
`timescale 1ns/1ps
module tb_simd_cmpavg_unit;

    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   op_prefix = 8'h66;
    logic [7:0]   op_escape = 8'h0F;
    logic [7:0]   op_code = 8'h00;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         out_valid;
    logic [W-1:0] result;
    logic         illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    simd_cmpavg_unit #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_prefix(op_prefix), .op_escape(op_escape), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .result(result), .illegal(illegal)
    );

    function automatic logic [W-1:0] m_eq(input logic [W-1:0] a, input logic [W-1:0] b, input int lw);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W / lw; i++) begin
            bit same = 1'b1;
            for (int k = 0; k < lw; k++) if (a[i*lw+k] != b[i*lw+k]) same = 1'b0;
            for (int k = 0; k < lw; k++) r[i*lw+k] = same;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] m_gt8(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W / 8; i++) begin
            int sa = int'(a[i*8 +: 8]);
            int sb = int'(b[i*8 +: 8]);
            if (sa > 127) sa = sa - 256;
            if (sb > 127) sb = sb - 256;
            r[i*8 +: 8] = (sa > sb) ? 8'hFF : 8'h00;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] m_avg(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W / 16; i++) begin
            int s = int'(a[i*16 +: 16]) + int'(b[i*16 +: 16]) + 1;
            r[i*16 +: 16] = 16'(s / 2);
        end
        return r;
    endfunction

    task automatic check_val(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one transaction, sample one cycle later, then go idle.
    task automatic issue(input string req, input logic [7:0] pfx, input logic [7:0] esc,
                         input logic [7:0] code, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] exp_r, input logic exp_ill);
        @(negedge clk);
        op_prefix = pfx; op_escape = esc; op_code = code;
        src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R2", "out_valid after accept", W'(out_valid), W'(1));
        check_val(req, "result", result, exp_r);
        check_val(req, "illegal", W'(illegal), W'(exp_ill));
    endtask

    task automatic t_reset;
        check_val("R1", "out_valid at reset", W'(out_valid), '0);
        check_val("R1", "illegal at reset", W'(illegal), '0);
        check_val("R1", "result at reset", result, '0);
        check_val("R1", "in_ready at reset", W'(in_ready), W'(1));
    endtask

    task automatic t_eq8;
        logic [W-1:0] a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        logic [W-1:0] b = 128'h00FF2233_44006677_88990ABB_CCDDEE7F;
        issue("R3", 8'h66, 8'h0F, 8'h74, a, b, m_eq(a, b, 8), 1'b0);
        issue("R3", 8'h66, 8'h0F, 8'h74, a, a, '1, 1'b0);
    endtask

    task automatic t_eq16;
        logic [W-1:0] a = 128'h1234_5678_9ABC_DEF0_0000_FFFF_1111_2222;
        logic [W-1:0] b = 128'h1234_5679_9ABC_DEF0_0100_FFFF_1111_2223;
        issue("R4", 8'h66, 8'h0F, 8'h75, a, b, m_eq(a, b, 16), 1'b0);
    endtask

    task automatic t_eq32;
        logic [W-1:0] a = 128'hDEADBEEF_00000000_CAFEF00D_80000001;
        logic [W-1:0] b = 128'hDEADBEEF_00010000_CAFEF00D_00000001;
        issue("R5", 8'h66, 8'h0F, 8'h76, a, b, m_eq(a, b, 32), 1'b0);
        check_val("R5", "eq32 lane mask", result,
                  128'hFFFFFFFF_00000000_FFFFFFFF_00000000);
    endtask

    task automatic t_gt8;
        // lanes: 7F>80, 80<7F, 00>FF, FF<00, equal, 01>00, 80=80, 7F=7F ...
        logic [W-1:0] a = 128'h7F80_00FF_5501_807F_0102_0304_FE7E_8110;
        logic [W-1:0] b = 128'h807F_FF00_5500_807F_0201_0403_7EFE_1081;
        issue("R6", 8'h66, 8'h0F, 8'h64, a, b, m_gt8(a, b), 1'b0);
        check_val("R6", "top two byte lanes", result[127:112], 16'hFF00);
    endtask

    task automatic t_avg;
        logic [W-1:0] a = 128'hFFFF_0000_FFFF_0001_8000_7FFF_1234_0003;
        logic [W-1:0] b = 128'hFFFF_0001_0000_0000_8000_8000_4321_0004;
        issue("R7", 8'h66, 8'h0F, 8'hE3, a, b, m_avg(a, b), 1'b0);
        check_val("R7", "carry kept in top lane", result[127:112], 16'hFFFF);
        // R8: lane of FFFF+FFFF next to lanes of 0+0 must not spill a carry
        a = 128'h0000_FFFF_0000_FFFF_0000_FFFF_0000_FFFF;
        b = 128'h0000_FFFF_0000_FFFF_0000_FFFF_0000_FFFF;
        issue("R8", 8'h66, 8'h0F, 8'hE3, a, b, a, 1'b0);
    endtask

    task automatic t_lane_iso;
        // R8: one differing bit at a lane top must not touch the neighbour lane
        logic [W-1:0] a = 128'h0;
        logic [W-1:0] b = 128'h0000_0000_0000_0000_0000_0000_0000_0080;
        issue("R8", 8'h66, 8'h0F, 8'h74, a, b, {{15{8'hFF}}, 8'h00}, 1'b0);
    endtask

    task automatic t_illegal;
        logic [W-1:0] a = 128'h0123456789ABCDEF_FEDCBA9876543210;
        logic [W-1:0] b = 128'h0;
        issue("R9", 8'h66, 8'h0F, 8'h65, a, b, a, 1'b0 | 1'b1);
        issue("R9", 8'h66, 8'h0F, 8'hE4, b, a, b, 1'b1);
        issue("R10", 8'h67, 8'h0F, 8'h74, a, a, a, 1'b1);
        issue("R10", 8'h66, 8'h0E, 8'hE3, a, b, a, 1'b1);
        // recognised opcode clears the illegal indication
        issue("R9", 8'h66, 8'h0F, 8'h76, a, b, m_eq(a, b, 32), 1'b0);
    endtask

    task automatic t_idle_hold;
        logic [W-1:0] held;
        logic         held_ill;
        held = result; held_ill = illegal;
        // inputs change but in_valid stays low
        op_code = 8'h74; src_a = '1; src_b = '0;
        @(negedge clk);
        check_val("R2", "out_valid idle", W'(out_valid), '0);
        check_val("R11", "result held", result, held);
        check_val("R11", "illegal held", W'(illegal), W'(held_ill));
        @(negedge clk);
        check_val("R11", "result held 2", result, held);
    endtask

    task automatic t_back_to_back;
        logic [W-1:0] a1 = 128'h11;
        logic [W-1:0] a2 = 128'hFFFF_0000;
        logic [W-1:0] b2 = 128'h0001_0002;
        @(negedge clk);
        op_prefix = 8'h66; op_escape = 8'h0F; op_code = 8'h74;
        src_a = a1; src_b = a1; in_valid = 1'b1;
        @(negedge clk);
        check_val("R2", "first of pair valid", W'(out_valid), W'(1));
        check_val("R3", "first of pair", result, '1);
        op_code = 8'hE3; src_a = a2; src_b = b2;
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R2", "second of pair valid", W'(out_valid), W'(1));
        check_val("R7", "second of pair", result, m_avg(a2, b2));
        @(negedge clk);
        check_val("R2", "drain after pair", W'(out_valid), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_eq8();
        t_eq16();
        t_eq32();
        t_gt8();
        t_avg();
        t_lane_iso();
        t_illegal();
        t_idle_hold();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule